// File: doc/BRIEF.md
# Pad Receive Event Detector

This block handles a single general-purpose pad. A 32-bit configuration word, written in one piece and always readable, selects how the pad input is turned into an event pulse for a status register further up. It also sets whether the pad driver is on, which value it drives, and which function owns the pad. The pad input passes through a synchronizer of two flops. It is then optionally inverted and handed to an event detector.

The detector has four modes, chosen by a 2-bit field. It can report an active level, report one edge, stay silent, or report every transition. A separate inversion bit turns a rising-edge detector into a falling-edge detector and turns an active-high level into an active-low one. The inversion bit has no effect when every transition is reported. The word's readback carries the live, synchronized receive state in place of the stored value for that bit. Bits that serve other pad features (termination, interrupt routing, spare positions) are held and read back without acting on anything.

Top module: `pad_evt_top`

## Requirements
- R1: After reset the configuration word reads 32'h0400_0100: event mode 2 (disabled) in bits 26:25, transmit driver disabled in bit 8, and every other bit 0. rx_event is low.
- R2: Level mode (bits 26:25 = 0). rx_event is high in every cycle in which the synchronized input XOR bit 23 is 1. A pad level presented before clock edge k is reflected on rx_event after edge k+2.
- R3: Edge mode (bits 26:25 = 1). A 0-to-1 change of the synchronized input XOR bit 23 gives exactly one cycle of rx_event, with the same latency as R2. With bit 23 set, this detects falling pad edges.
- R4: Both-edge mode (bits 26:25 = 3). Every change of the synchronized input gives one cycle of rx_event, whatever the value of bit 23.
- R5: Disabled mode (bits 26:25 = 2). rx_event stays low regardless of pad activity.
- R6: While bit 9 (receive disable) is set, rx_event stays low and bit 1 of the readback is 0.
- R7: Readback bit 1 shows the pad input after the two-flop synchronizer. Writes to bit 1 are ignored.
- R8: Every bit other than bit 1 reads back exactly as last written, including bits that control nothing.
- R9: pad_oe is 1 only when bit 8 is 0 and the function field in bits 13:10 is 0 (GPIO use). pad_out follows bit 0.
- R10: gpio_value equals bit 0 while bit 8 is 0, and equals readback bit 1 while bit 8 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Load cfg_wr_data into the configuration word |
| cfg_wr_data | input | 32 | Configuration value to write |
| cfg_rd_data | output | 32 | Configuration readback, with the live receive state in bit 1 |
| pad_in | input | 1 | Asynchronous pad input |
| pad_out | output | 1 | Value driven onto the pad |
| pad_oe | output | 1 | Pad driver enable |
| gpio_value | output | 1 | Effective pad value seen by software |
| rx_event | output | 1 | Event pulse toward the status register |

## Verification
The hardest case to reach from the ports is a falling-edge event. It needs inversion, edge mode, and a detector history that has already settled on the inverted idle level. Changing the inversion bit by itself creates a spurious edge in the detector history. The stimulus therefore writes the configuration, holds the pad idle for several cycles so that this edge drains away, and only then plays an 8-step pad pattern. It compares the 8 event samples that lag the pattern by three clock edges. The same patterns are replayed in every mode, with and without inversion, so the expected event bytes differ only by mode.

// File: rtl/pad_evt_pkg.sv
package pad_evt_pkg;

    localparam int CFG_W = 32;

    typedef enum logic [1:0] {
        EVM_LEVEL = 2'd0,
        EVM_EDGE  = 2'd1,
        EVM_OFF   = 2'd2,
        EVM_ANY   = 2'd3
    } evt_mode_e;

    // Field placement of the configuration word
    typedef struct packed {
        logic [4:0] spare_hi;   // 31:27
        evt_mode_e  evt_mode;   // 26:25
        logic       spare_24;   // 24
        logic       rx_flip;    // 23
        logic [8:0] route_etc;  // 22:14 stored only
        logic [3:0] fn_sel;     // 13:10
        logic       rx_off;     // 9
        logic       tx_off;     // 8
        logic [5:0] term_etc;   // 7:2 stored only
        logic       rx_live;    // 1 read-only
        logic       tx_val;     // 0
    } pad_cfg_t;

    localparam logic [CFG_W-1:0] CFG_RESET   = 32'h0400_0100;
    localparam int               RX_LIVE_BIT = 1;
    localparam logic [CFG_W-1:0] CFG_WMASK   = ~(CFG_W'(1) << RX_LIVE_BIT);
    localparam logic [3:0]       FN_GPIO     = 4'd0;

    function automatic logic event_hit(evt_mode_e mode, logic cur, logic prv);
        logic hit;
        case (mode)
            EVM_LEVEL: hit = cur;
            EVM_EDGE:  hit = cur & ~prv;
            EVM_ANY:   hit = cur ^ prv;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pad_evt_sync.sv
module pad_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/pad_evt_cfg.sv
module pad_evt_cfg
    import pad_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             rx_live,
    output pad_cfg_t         cfg_q,
    output logic [CFG_W-1:0] rd_data
);
    pad_cfg_t view;

    always_ff @(posedge clk) begin
        if (rst)        cfg_q <= pad_cfg_t'(CFG_RESET);
        else if (wr_en) cfg_q <= pad_cfg_t'(wr_data & CFG_WMASK);
    end

    always_comb begin
        view         = cfg_q;
        view.rx_live = rx_live;
        rd_data      = CFG_W'(view);
    end
endmodule

// File: rtl/pad_evt_detect.sv
module pad_evt_detect
    import pad_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_sync,
    input  evt_mode_e mode,
    input  logic      flip,
    input  logic      rx_off,
    output logic      evt
);
    logic cur;
    logic prv_q;

    assign cur = rx_sync ^ flip;

    always_ff @(posedge clk) begin
        if (rst) begin
            prv_q <= 1'b0;
            evt   <= 1'b0;
        end else begin
            prv_q <= cur;
            evt   <= ~rx_off & event_hit(mode, cur, prv_q);
        end
    end
endmodule

// File: rtl/pad_evt_top.sv
module pad_evt_top
    import pad_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wr_data,
    output logic [CFG_W-1:0] cfg_rd_data,
    input  logic             pad_in,
    output logic             pad_out,
    output logic             pad_oe,
    output logic             gpio_value,
    output logic             rx_event
);
    pad_cfg_t cfg_q;
    logic     pad_sync;
    logic     rx_live;

    pad_evt_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (pad_in),
        .dout (pad_sync)
    );

    assign rx_live = pad_sync & ~cfg_q.rx_off;

    pad_evt_cfg cfg_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .rx_live (rx_live),
        .cfg_q   (cfg_q),
        .rd_data (cfg_rd_data)
    );

    pad_evt_detect det_i (
        .clk     (clk),
        .rst     (rst),
        .rx_sync (rx_live),
        .mode    (cfg_q.evt_mode),
        .flip    (cfg_q.rx_flip),
        .rx_off  (cfg_q.rx_off),
        .evt     (rx_event)
    );

    assign pad_oe     = ~cfg_q.tx_off & (cfg_q.fn_sel == FN_GPIO);
    assign pad_out    = cfg_q.tx_val;
    assign gpio_value = cfg_q.tx_off ? rx_live : cfg_q.tx_val;
endmodule

// File: rtl/pad_evt_chk.sv
module pad_evt_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] cfg_rd_data,
    input logic        rx_event,
    input logic        pad_oe,
    input logic        pad_out,
    input logic        gpio_value
);
    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_data[26:25] == 2'd2) |=> !rx_event);

    a_r3_edge_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (rx_event && cfg_rd_data[26:25] == 2'd1 && $past(cfg_rd_data[26:25]) == 2'd1)
        |=> !rx_event);

    a_r6_rxoff_quiet: assert property (@(posedge clk) disable iff (rst)
        cfg_rd_data[9] |=> !rx_event);

    a_r9_drive_value: assert property (@(posedge clk) disable iff (rst)
        pad_oe |-> (pad_out == cfg_rd_data[0] && !cfg_rd_data[8]));

    a_r10_value_tx: assert property (@(posedge clk) disable iff (rst)
        !cfg_rd_data[8] |-> (gpio_value == cfg_rd_data[0]));

    a_r10_value_rx: assert property (@(posedge clk) disable iff (rst)
        cfg_rd_data[8] |-> (gpio_value == cfg_rd_data[1]));
endmodule

bind pad_evt_top pad_evt_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_rd_data (cfg_rd_data),
    .rx_event    (rx_event),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .gpio_value  (gpio_value)
);

// File: tb/pad_evt_top_tb_top.sv
module pad_evt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic        pad_in = 1'b0;
    logic        pad_out, pad_oe, gpio_value, rx_event;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pad_evt_top dut_i (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .gpio_value(gpio_value), .rx_event(rx_event)
    );

    // {config word, pad pattern (bit i = step i), expected events}
    localparam int NV = 12;
    localparam logic [47:0] VEC [NV] = '{
        {32'h0000_0100, 8'hD3, 8'hD3},   // R2 level
        {32'h0080_0100, 8'hD3, 8'h2C},   // R2 level, active low
        {32'h0200_0100, 8'hD3, 8'h51},   // R3 rising
        {32'h0280_0100, 8'hD3, 8'h24},   // R3 falling
        {32'h0600_0100, 8'hD3, 8'h75},   // R4 both
        {32'h0680_0100, 8'hD3, 8'h75},   // R4 both, inversion ignored
        {32'h0400_0100, 8'hD3, 8'h00},   // R5 disabled
        {32'h0200_0100, 8'hA5, 8'hA5},   // R3 rising
        {32'h0280_0100, 8'hA5, 8'h4A},   // R3 falling
        {32'h0600_0100, 8'hA5, 8'hEF},   // R4 both
        {32'h0000_0100, 8'hA5, 8'hA5},   // R2 level
        {32'h0080_0100, 8'hA5, 8'h5A}    // R2 level, active low
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] w);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = w;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R5";
            default: return "R4";
        endcase
    endfunction

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 reset word", cfg_rd_data, 32'h0400_0100);
        check("R1 reset event", {31'd0, rx_event}, 32'd0);

        // Table walk: R2..R5
        for (int v = 0; v < NV; v++) begin
            logic [7:0] got;
            logic [7:0] pat;
            pad_in = 1'b0;
            cfg_write(VEC[v][47:16]);
            idle(6);
            pat = VEC[v][15:8];
            got = '0;
            for (int i = 0; i < 11; i++) begin
                @(negedge clk);
                if (i >= 3) got[i-3] = rx_event;
                if (i < 8) pad_in = pat[i];
            end
            check(mode_req(VEC[v][42:41]), {24'd0, got}, {24'd0, VEC[v][7:0]});
            pad_in = 1'b0;
            idle(6);
        end

        // R7 write to bit 1 ignored, pad low
        cfg_write(32'h0400_0102);
        check("R7 write ignored", cfg_rd_data, 32'h0400_0100);
        // R7 live state follows synchronized pad
        pad_in = 1'b1;
        idle(1);
        check("R7 not yet synced", {31'd0, cfg_rd_data[1]}, 32'd0);
        idle(1);
        check("R7 live high", {31'd0, cfg_rd_data[1]}, 32'd1);
        // R10 tx disabled: value follows receive
        check("R10 rx value", {31'd0, gpio_value}, 32'd1);

        // R6 receive disabled in level mode with pad high
        cfg_write(32'h0000_0300);
        idle(4);
        check("R6 no event", {31'd0, rx_event}, 32'd0);
        check("R6 rx state low", {31'd0, cfg_rd_data[1]}, 32'd0);
        check("R10 rx disabled value", {31'd0, gpio_value}, 32'd0);

        // R9/R10 driving GPIO with pad input low
        pad_in = 1'b0;
        cfg_write(32'h0400_0001);
        check("R9 oe on", {31'd0, pad_oe}, 32'd1);
        check("R9 out value", {31'd0, pad_out}, 32'd1);
        check("R10 tx value", {31'd0, gpio_value}, 32'd1);
        // R9 non-GPIO function blocks driver
        cfg_write(32'h0400_0C01);
        check("R9 oe off in function 3", {31'd0, pad_oe}, 32'd0);

        // R8 full stored readback (bit 1 forced to pad state 0)
        cfg_write(32'hA8F5_5A7E);
        check("R8 readback", cfg_rd_data, 32'hA8F5_5A7C);
        cfg_write(32'h5300_A581);
        check("R8 readback 2", cfg_rd_data, 32'h5300_A581);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule